// File: doc/BRIEF.md
# Amplifier control and diagnostic register interface

This block is the two-wire serial slave that sits in front of a four-channel amplifier controller. A host writes two instruction bytes that set standby, per-pair mute and gain, clip threshold, diagnostic enables, the current threshold for the AC tweeter check, fast mute, line-driver thresholds and the efficiency mode. The block drives these as decoded control bits to the rest of the chip. A read returns four diagnostic bytes. Each byte carries the status of one channel, plus thermal warnings and a few flags.

The diagnostic results come from engines outside this block as per-channel status inputs. A read does not sample them live. The status is frozen into a snapshot at the address acknowledge of a read, and the STOP that closes the read sends a one-cycle re-arm pulse that restarts every diagnostic cycle. A read therefore returns the outcome of the cycle that the previous read started, and a cleared fault disappears only on the second read after it clears.

A strap input supplies bit 1 of the 7-bit slave address. A second strap turns the serial interface off. While it is asserted the bus lines act as plain pins: the clock line selects high-efficiency mode and the data line selects low gain.

Top module: `amp_diag_if`

## Requirements
- R1: After reset every control output is 0. This means standby (run_o=0), both pairs muted, high gain, diagnostics off and standard efficiency. The data line is released (sda_oe_o=0) and rearm_o is 0.
- R2: The slave address is 110110 followed by addr_sel_i, sent MSB first. The R/W bit follows (0 write, 1 read). A matching address is acknowledged by pulling SDA low. A non-matching address is not acknowledged, and the rest of that transfer changes no output.
- R3: In a write, the first data byte is instruction byte 1 and the second is instruction byte 2, and both are acknowledged. Any further byte is not acknowledged and has no effect.
- R4: Instruction byte 1 bits map as follows: bit 6 to diag_en_o, bit 5 to offset_en_o, bit 4 to gain_lo_front_o, bit 3 to gain_lo_rear_o, bit 2 to unmute_front_o, bit 1 to unmute_rear_o and bit 0 to clip_hi_o. Bit 7 is ignored.
- R5: Instruction byte 2 bits map as follows: bit 7 to cur_thr_lo_o, bit 5 to fast_mute_o, bit 4 to run_o, bit 3 to line_drv_o, bit 2 to ac_diag_en_o and bits 1:0 to he_mode_o. Bit 6 is ignored.
- R6: A byte takes effect only once all 8 of its bits are received. A STOP after byte 1, or in the middle of byte 2, leaves instruction byte 2 unchanged.
- R7: A read returns four bytes. Bits 5:0 of each byte are one channel's 6-bit status field ch_stat_i[6(n-1)+5 : 6(n-1)] for channel n. The channel order is 3, 4, 1, 2.
- R8: The upper bits of the read bytes are as follows. Byte 1 carries therm_warn_i[0] in bit 7 and cycle_done_i in bit 6. Byte 2 carries offset_busy_i in bit 7 and 0 in bit 6. Byte 3 carries run_o in bit 7 and diag_en_o in bit 6. Byte 4 carries therm_warn_i[1] in bit 7 and therm_warn_i[2] in bit 6.
- R9: All read bytes come from a snapshot taken at the address acknowledge of the read. Input changes after that point appear only in the next read.
- R10: The STOP that ends a read raises rearm_o for exactly one clock cycle. Write transfers never raise it.
- R11: While bus_dis_i is 1, the bus is ignored: SDA is never driven, the instruction registers do not change and rearm_o stays low. In this state he_mode_o is {scl_i, scl_i}, and both gain-low outputs follow sda_i.
- R12: If the host acknowledges the fourth read byte, later bytes read as 0xFF with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| addr_sel_i | input | 1 | Strap for address bit 1 |
| bus_dis_i | input | 1 | Strap: 1 turns the bus off and selects pin control |
| ch_stat_i | input | 24 | Four 6-bit channel status fields, channel 1 in the LSBs |
| therm_warn_i | input | 3 | Three thermal warning levels |
| cycle_done_i | input | 1 | A diagnostic cycle has terminated |
| offset_busy_i | input | 1 | Offset detection is active |
| diag_en_o | output | 1 | Diagnostic enable |
| offset_en_o | output | 1 | Offset detection enable |
| gain_lo_front_o | output | 1 | Front pair low gain |
| gain_lo_rear_o | output | 1 | Rear pair low gain |
| unmute_front_o | output | 1 | Front pair unmuted |
| unmute_rear_o | output | 1 | Rear pair unmuted |
| clip_hi_o | output | 1 | Higher clip-detect threshold |
| cur_thr_lo_o | output | 1 | Low current threshold for the AC check |
| fast_mute_o | output | 1 | Fast mute |
| run_o | output | 1 | Out of standby |
| line_drv_o | output | 1 | Line-driver diagnostic thresholds |
| ac_diag_en_o | output | 1 | AC current diagnostic enable |
| he_mode_o | output | 2 | High-efficiency mode select |
| rearm_o | output | 1 | One-cycle pulse that restarts the diagnostic cycles |

## Verification
Bus pins pass through two synchronizer flops and one edge register. An instruction byte therefore reaches the control outputs about four clock cycles after the SCL fall that follows its eighth bit, and the acknowledge drive appears on the same schedule. The bench checks control outputs only after the closing STOP and a quarter-bit wait of eight cycles. It samples acknowledges and read data a full quarter-bit after SCL rises, which is well past both latencies. The rearm_o pulse is due about four cycles after the STOP, so it is counted at every falling clock edge and the count is compared after the STOP wait. The pin-control outputs under bus_dis_i lag the pins by three cycles, and the bench waits ten cycles before checking them.

// File: rtl/amp_if_pkg.sv
package amp_if_pkg;
  localparam int BYTE_W   = 8;
  localparam int STAT_W   = 6;
  localparam int NUM_CH   = 4;
  localparam int CNT_W    = 4;
  localparam int IDX_W    = 3;
  localparam int WR_BYTES = 2;
  localparam int RD_BYTES = 4;
  localparam logic [5:0] ADDR_HI = 6'b110110;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_WR_DATA, S_WR_ACK, S_RD_DATA, S_RD_ACK, S_IGNORE
  } i2c_state_e;

  typedef struct packed {
    logic diag_en;
    logic offset_en;
    logic gain_lo_front;
    logic gain_lo_rear;
    logic unmute_front;
    logic unmute_rear;
    logic clip_hi;
  } ctl1_t;

  typedef struct packed {
    logic       cur_thr_lo;
    logic       fast_mute;
    logic       run;
    logic       line_drv;
    logic       ac_diag_en;
    logic [1:0] he_mode;
  } ctl2_t;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int N_SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic [N_SYNC-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[N_SYNC-2:0], scl_i};
      sda_ff <= {sda_ff[N_SYNC-2:0], sda_i};
      scl_d  <= scl_ff[N_SYNC-1];
      sda_d  <= sda_ff[N_SYNC-1];
    end
  end

  assign scl_o      = scl_ff[N_SYNC-1];
  assign sda_o      = sda_ff[N_SYNC-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import amp_if_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              addr_bit_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr1_we_o,
  output logic              wr2_we_o,
  output logic              snap_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              rearm_o
);
  localparam logic [CNT_W-1:0] BITS    = CNT_W'(BYTE_W);
  localparam logic [IDX_W-1:0] WR_END  = IDX_W'(WR_BYTES);
  localparam logic [IDX_W-1:0] RD_END  = IDX_W'(RD_BYTES);

  i2c_state_e        state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q, tx_q;
  logic [IDX_W-1:0]  byte_idx_q;
  logic              rw_q, rd_txn_q, mack_q, rearm_q;
  logic              addr_done, addr_hit, wr_done;

  assign addr_hit  = (shreg_q[7:1] == {ADDR_HI, addr_bit_i});
  assign addr_done = (state_q == S_ADDR) && scl_fall_i && (bit_cnt_q == BITS);
  assign wr_done   = (state_q == S_WR_DATA) && scl_fall_i && (bit_cnt_q == BITS);
  assign snap_o    = en_i && !stop_i && !start_i && addr_done && addr_hit && shreg_q[0];
  assign wr1_we_o  = en_i && !stop_i && !start_i && wr_done && (byte_idx_q == '0);
  assign wr2_we_o  = en_i && !stop_i && !start_i && wr_done && (byte_idx_q == IDX_W'(1));
  assign wr_data_o = shreg_q;
  assign rd_idx_o  = byte_idx_q;
  assign rearm_o   = rearm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      tx_q       <= '1;
      byte_idx_q <= '0;
      rw_q       <= 1'b0;
      rd_txn_q   <= 1'b0;
      mack_q     <= 1'b0;
      rearm_q    <= 1'b0;
    end else if (!en_i) begin
      state_q  <= S_IDLE;
      rd_txn_q <= 1'b0;
      rearm_q  <= 1'b0;
    end else begin
      rearm_q <= 1'b0;
      if (stop_i) begin
        state_q  <= S_IDLE;
        rearm_q  <= rd_txn_q;
        rd_txn_q <= 1'b0;
      end else if (start_i) begin
        state_q   <= S_ADDR;
        bit_cnt_q <= '0;
      end else begin
        if (scl_rise_i && (state_q == S_ADDR || state_q == S_WR_DATA) && bit_cnt_q != BITS) begin
          shreg_q   <= {shreg_q[BYTE_W-2:0], sda_i};
          bit_cnt_q <= bit_cnt_q + CNT_W'(1);
        end
        if (scl_rise_i && state_q == S_RD_ACK) begin
          mack_q <= ~sda_i;
          if (!sda_i && byte_idx_q != RD_END) byte_idx_q <= byte_idx_q + IDX_W'(1);
        end
        if (scl_fall_i) begin
          case (state_q)
            S_ADDR: if (bit_cnt_q == BITS) begin
              if (addr_hit) begin
                state_q    <= S_ADDR_ACK;
                rw_q       <= shreg_q[0];
                byte_idx_q <= '0;
                if (shreg_q[0]) rd_txn_q <= 1'b1;
              end else begin
                state_q <= S_IGNORE;
              end
            end
            S_ADDR_ACK: begin
              bit_cnt_q <= '0;
              if (rw_q) begin
                tx_q    <= rd_byte_i;
                state_q <= S_RD_DATA;
              end else begin
                state_q <= S_WR_DATA;
              end
            end
            S_WR_DATA: if (bit_cnt_q == BITS) begin
              if (byte_idx_q < WR_END) begin
                state_q    <= S_WR_ACK;
                byte_idx_q <= byte_idx_q + IDX_W'(1);
              end else begin
                state_q <= S_IGNORE;
              end
            end
            S_WR_ACK: begin
              bit_cnt_q <= '0;
              state_q   <= S_WR_DATA;
            end
            S_RD_DATA: begin
              if (bit_cnt_q == BITS - CNT_W'(1)) begin
                state_q <= S_RD_ACK;
              end else begin
                tx_q      <= {tx_q[BYTE_W-2:0], 1'b1};
                bit_cnt_q <= bit_cnt_q + CNT_W'(1);
              end
            end
            S_RD_ACK: begin
              if (mack_q) begin
                tx_q      <= rd_byte_i;
                bit_cnt_q <= '0;
                state_q   <= S_RD_DATA;
              end else begin
                state_q <= S_IGNORE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (state_q)
      S_ADDR_ACK, S_WR_ACK: sda_oe_o = 1'b1;
      S_RD_DATA:            sda_oe_o = ~tx_q[BYTE_W-1];
      default:              sda_oe_o = 1'b0;
    endcase
  end

  AST_REARM_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_o |=> !rearm_o); // R10
  AST_ADDR_ACK_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == S_ADDR_ACK) |-> $past(shreg_q[7:1]) == {ADDR_HI, $past(addr_bit_i)}); // R2
  AST_DIS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $past(!en_i)) |-> (!sda_oe_o && !rearm_o)); // R11
  AST_RD_TAIL_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RD_DATA && byte_idx_q == RD_END) |-> !sda_oe_o); // R12
endmodule

// File: rtl/amp_ctrl_regs.sv
module amp_ctrl_regs
  import amp_if_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr1_we_i,
  input  logic              wr2_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              bus_dis_i,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  output ctl1_t             ctl1_o,
  output ctl2_t             ctl2_o
);
  ctl1_t ctl1_q;
  ctl2_t ctl2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl1_q <= '0;
      ctl2_q <= '0;
    end else begin
      if (wr1_we_i) ctl1_q <= ctl1_t'(wdata_i[6:0]);
      if (wr2_we_i) ctl2_q <= ctl2_t'({wdata_i[7], wdata_i[5:0]});
    end
  end

  // pin-control fallback overrides gain and efficiency selects
  always_comb begin
    ctl1_o = ctl1_q;
    ctl2_o = ctl2_q;
    if (bus_dis_i) begin
      ctl1_o.gain_lo_front = sda_s_i;
      ctl1_o.gain_lo_rear  = sda_s_i;
      ctl2_o.he_mode       = {scl_s_i, scl_s_i};
    end
  end

  AST_CTL1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr1_we_i |=> $stable(ctl1_q)); // R3
  AST_CTL2_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr2_we_i |=> $stable(ctl2_q)); // R6
  AST_DIS_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_dis_i |-> !(wr1_we_i || wr2_we_i)); // R11
endmodule

// File: rtl/diag_snapshot.sv
module diag_snapshot
  import amp_if_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     snap_i,
  input  logic [NUM_CH*STAT_W-1:0] ch_stat_i,
  input  logic [2:0]               therm_i,
  input  logic                     cycle_done_i,
  input  logic                     offset_busy_i,
  input  logic                     run_i,
  input  logic                     diag_en_i,
  input  logic [IDX_W-1:0]         idx_i,
  output logic [BYTE_W-1:0]        byte_o
);
  localparam int SEL_W = $clog2(NUM_CH);

  logic [NUM_CH-1:0][BYTE_W-1:0] snap_q, snap_d;

  // read byte k carries channel index k^2 (order 3,4,1,2)
  for (genvar k = 0; k < NUM_CH; k++) begin : g_byte
    localparam int CH = k ^ 2;
    assign snap_d[k][STAT_W-1:0] = ch_stat_i[CH*STAT_W +: STAT_W];
  end
  assign snap_d[0][BYTE_W-1:STAT_W] = {therm_i[0], cycle_done_i};
  assign snap_d[1][BYTE_W-1:STAT_W] = {offset_busy_i, 1'b0};
  assign snap_d[2][BYTE_W-1:STAT_W] = {run_i, diag_en_i};
  assign snap_d[3][BYTE_W-1:STAT_W] = {therm_i[1], therm_i[2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snap_q <= '0;
    else if (snap_i) snap_q <= snap_d;
  end

  assign byte_o = (idx_i < IDX_W'(NUM_CH)) ? snap_q[idx_i[SEL_W-1:0]] : '1;

  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(snap_q)); // R9
  AST_TAIL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i >= IDX_W'(NUM_CH)) |-> (byte_o == '1)); // R12
endmodule

// File: rtl/amp_diag_if.sv
module amp_diag_if
  import amp_if_pkg::*;
#(
  parameter int N_SYNC = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic        addr_sel_i,
  input  logic        bus_dis_i,
  input  logic [23:0] ch_stat_i,
  input  logic [2:0]  therm_warn_i,
  input  logic        cycle_done_i,
  input  logic        offset_busy_i,
  output logic        diag_en_o,
  output logic        offset_en_o,
  output logic        gain_lo_front_o,
  output logic        gain_lo_rear_o,
  output logic        unmute_front_o,
  output logic        unmute_rear_o,
  output logic        clip_hi_o,
  output logic        cur_thr_lo_o,
  output logic        fast_mute_o,
  output logic        run_o,
  output logic        line_drv_o,
  output logic        ac_diag_en_o,
  output logic [1:0]  he_mode_o,
  output logic        rearm_o
);
  logic scl_s, sda_s, start, stop, scl_rise, scl_fall;
  logic wr1_we, wr2_we, snap;
  logic [BYTE_W-1:0] wr_data, rd_byte;
  logic [IDX_W-1:0]  rd_idx;
  ctl1_t ctl1;
  ctl2_t ctl2;

  i2c_bus_sync #(.N_SYNC(N_SYNC)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .start_o(start), .stop_o(stop),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
  );

  i2c_slave_fsm u_fsm (
    .clk_i, .rst_ni, .en_i(!bus_dis_i), .addr_bit_i(addr_sel_i), .sda_i(sda_s),
    .start_i(start), .stop_i(stop), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .rd_byte_i(rd_byte), .sda_oe_o, .wr_data_o(wr_data), .wr1_we_o(wr1_we),
    .wr2_we_o(wr2_we), .snap_o(snap), .rd_idx_o(rd_idx), .rearm_o
  );

  amp_ctrl_regs u_regs (
    .clk_i, .rst_ni, .wr1_we_i(wr1_we), .wr2_we_i(wr2_we), .wdata_i(wr_data),
    .bus_dis_i, .scl_s_i(scl_s), .sda_s_i(sda_s), .ctl1_o(ctl1), .ctl2_o(ctl2)
  );

  diag_snapshot u_snap (
    .clk_i, .rst_ni, .snap_i(snap), .ch_stat_i, .therm_i(therm_warn_i),
    .cycle_done_i, .offset_busy_i, .run_i(ctl2.run), .diag_en_i(ctl1.diag_en),
    .idx_i(rd_idx), .byte_o(rd_byte)
  );

  assign diag_en_o       = ctl1.diag_en;
  assign offset_en_o     = ctl1.offset_en;
  assign gain_lo_front_o = ctl1.gain_lo_front;
  assign gain_lo_rear_o  = ctl1.gain_lo_rear;
  assign unmute_front_o  = ctl1.unmute_front;
  assign unmute_rear_o   = ctl1.unmute_rear;
  assign clip_hi_o       = ctl1.clip_hi;
  assign cur_thr_lo_o    = ctl2.cur_thr_lo;
  assign fast_mute_o     = ctl2.fast_mute;
  assign run_o           = ctl2.run;
  assign line_drv_o      = ctl2.line_drv;
  assign ac_diag_en_o    = ctl2.ac_diag_en;
  assign he_mode_o       = ctl2.he_mode;
endmodule

// File: tb/sim_amp_diag_if.sv
module sim_amp_diag_if;
  localparam int Q = 8;
  localparam logic [6:0] ADR0 = 7'b1101100;
  localparam logic [6:0] ADR1 = 7'b1101101;
  localparam int NVEC = 6;
  // {ctl byte 1, ctl byte 2, expected observed word}
  localparam logic [29:0] VEC [NVEC] = '{
    {8'h7F, 8'hBF, 14'h3FFF},
    {8'h00, 8'h00, 14'h0000},
    {8'h40, 8'h10, 14'h2010},
    {8'h15, 8'h84, 14'h0AC4},
    {8'h2A, 8'h23, 14'h1523},
    {8'hC1, 8'h48, 14'h2088}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_sel = 1'b0, bus_dis = 1'b0;
  logic [23:0] ch_stat = '0;
  logic [2:0] therm = '0;
  logic cyc_done = 1'b0, off_busy = 1'b0;
  logic sda_oe, diag_en, offset_en, g_f, g_r, um_f, um_r, clip_hi, cur_lo, fast, run, line, ac, rearm;
  logic [1:0] he;
  wire sda_line = sda_m & ~sda_oe;
  wire [13:0] obs = {diag_en, offset_en, g_f, g_r, um_f, um_r, clip_hi, cur_lo, fast, run, line, ac, he};

  int n_tests = 0, n_fail = 0, rearm_cnt = 0;
  logic [7:0] rd_buf [6];

  amp_diag_if u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .bus_dis_i(bus_dis), .ch_stat_i(ch_stat), .therm_warn_i(therm),
    .cycle_done_i(cyc_done), .offset_busy_i(off_busy), .diag_en_o(diag_en), .offset_en_o(offset_en),
    .gain_lo_front_o(g_f), .gain_lo_rear_o(g_r), .unmute_front_o(um_f), .unmute_rear_o(um_r),
    .clip_hi_o(clip_hi), .cur_thr_lo_o(cur_lo), .fast_mute_o(fast), .run_o(run),
    .line_drv_o(line), .ac_diag_en_o(ac), .he_mode_o(he), .rearm_o(rearm)
  );

  always @(negedge clk) if (rst_n && rearm) rearm_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic i2c_start(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq(); endtask
  task automatic i2c_stop(); sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq(); endtask
  task automatic send_bit(input logic b); sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq(); endtask
  task automatic recv_bit(output logic b); sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq(); endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic mack);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(!mack);
  endtask

  task automatic write2(input logic [6:0] a, input logic [7:0] b1, input logic [7:0] b2,
                        output logic ka, output logic k1, output logic k2);
    i2c_start(); wr_byte({a, 1'b0}, ka); wr_byte(b1, k1); wr_byte(b2, k2); i2c_stop();
  endtask

  task automatic read_n(input int n, output logic ka);
    i2c_start(); wr_byte({ADR0, 1'b1}, ka);
    for (int i = 0; i < n; i++) rd_byte(rd_buf[i], i < n - 1);
    i2c_stop();
  endtask

  function automatic logic [7:0] exp_db(input int k, input logic [23:0] cs, input logic [2:0] th,
                                        input logic cd, input logic ob, input logic rn, input logic de);
    logic [5:0] st;
    st = cs[(k ^ 2) * 6 +: 6];
    case (k)
      0:       return {th[0], cd, st};
      1:       return {ob, 1'b0, st};
      2:       return {rn, de, st};
      default: return {th[1], th[2], st};
    endcase
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic ka, k1, k2, k3;
    logic [23:0] cs_old;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 controls after reset", 32'(obs), 32'h0);
    chk("R1 sda released", 32'(sda_oe), 32'h0);
    chk("R1 rearm low", 32'(rearm), 32'h0);

    // R4 R5 vector walk
    for (int v = 0; v < NVEC; v++) begin
      write2(ADR0, VEC[v][29:22], VEC[v][21:14], ka, k1, k2);
      chk("R2 address ack", 32'(ka), 32'h1);
      chk("R3 data acks", 32'({k1, k2}), 32'h3);
      chk("R4 R5 decoded controls", 32'(obs), 32'(VEC[v][13:0]));
    end
    chk("R10 no rearm on writes", 32'(rearm_cnt), 32'h0);

    // R2 wrong address ignored, then strap moves the address
    write2(ADR1, 8'hFF, 8'hFF, ka, k1, k2);
    chk("R2 mismatch nack", 32'(ka), 32'h0);
    chk("R2 mismatch no effect", 32'(obs), 32'h2088);
    addr_sel = 1'b1;
    write2(ADR1, 8'h40, 8'h10, ka, k1, k2);
    chk("R2 strap address ack", 32'(ka), 32'h1);
    chk("R2 strap address write", 32'(obs), 32'h2010);
    addr_sel = 1'b0;

    // R3 third byte refused
    i2c_start(); wr_byte({ADR0, 1'b0}, ka); wr_byte(8'h15, k1); wr_byte(8'h84, k2); wr_byte(8'hFF, k3); i2c_stop();
    chk("R3 third byte nack", 32'(k3), 32'h0);
    chk("R3 third byte no effect", 32'(obs), 32'h0AC4);

    // R6 partial transfers
    write2(ADR0, 8'h2A, 8'h23, ka, k1, k2);
    i2c_start(); wr_byte({ADR0, 1'b0}, ka); wr_byte(8'h40, k1); i2c_stop();
    chk("R6 stop after first byte", 32'(obs), 32'h2023);
    i2c_start(); wr_byte({ADR0, 1'b0}, ka); wr_byte(8'h15, k1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    i2c_stop();
    chk("R6 stop mid second byte", 32'(obs), 32'h0AA3);

    // R7 R8 read contents
    write2(ADR0, 8'h40, 8'h10, ka, k1, k2);
    ch_stat = {6'h2A, 6'h15, 6'h33, 6'h0C}; therm = 3'b101; cyc_done = 1'b1; off_busy = 1'b1;
    read_n(4, ka);
    chk("R2 read address ack", 32'(ka), 32'h1);
    for (int k = 0; k < 4; k++)
      chk("R7 R8 read byte", 32'(rd_buf[k]), 32'(exp_db(k, ch_stat, therm, 1'b1, 1'b1, 1'b1, 1'b1)));
    chk("R10 one rearm per read", 32'(rearm_cnt), 32'h1);

    // R9 snapshot at address ack
    cs_old = ch_stat;
    i2c_start(); wr_byte({ADR0, 1'b1}, ka);
    ch_stat = {6'h01, 6'h02, 6'h04, 6'h08}; therm = 3'b010; cyc_done = 1'b0; off_busy = 1'b0;
    for (int i = 0; i < 4; i++) rd_byte(rd_buf[i], i < 3);
    i2c_stop();
    for (int k = 0; k < 4; k++)
      chk("R9 old snapshot", 32'(rd_buf[k]), 32'(exp_db(k, cs_old, 3'b101, 1'b1, 1'b1, 1'b1, 1'b1)));
    read_n(4, ka);
    for (int k = 0; k < 4; k++)
      chk("R9 next read shows update", 32'(rd_buf[k]), 32'(exp_db(k, ch_stat, therm, 1'b0, 1'b0, 1'b1, 1'b1)));
    chk("R10 rearm count after reads", 32'(rearm_cnt), 32'h3);

    // R12 bytes past the fourth
    read_n(6, ka);
    chk("R12 fifth byte", 32'(rd_buf[4]), 32'hFF);
    chk("R12 sixth byte", 32'(rd_buf[5]), 32'hFF);
    chk("R7 byte four intact", 32'(rd_buf[3]), 32'(exp_db(3, ch_stat, therm, 1'b0, 1'b0, 1'b1, 1'b1)));

    // R11 pin-control fallback
    bus_dis = 1'b1; scl_m = 1'b1; sda_m = 1'b0;
    repeat (10) @(negedge clk);
    chk("R11 clock pin sets he", 32'(he), 32'h3);
    chk("R11 data pin low gain off", 32'({g_f, g_r}), 32'h0);
    sda_m = 1'b1; scl_m = 1'b0;
    repeat (10) @(negedge clk);
    chk("R11 clock pin clears he", 32'(he), 32'h0);
    chk("R11 data pin low gain on", 32'({g_f, g_r}), 32'h3);
    write2(ADR0, 8'h7F, 8'hBF, ka, k1, k2);
    chk("R11 bus ignored nack", 32'(ka), 32'h0);
    chk("R11 other controls held", 32'(obs & 14'h33FC), 32'h2010);
    read_n(1, ka);
    chk("R11 no rearm when disabled", 32'(rearm_cnt), 32'h4);
    bus_dis = 1'b0;
    repeat (10) @(negedge clk);
    chk("R11 registers kept", 32'(obs), 32'h2010);

    finish_run();
  end
endmodule